// File: doc/BRIEF.md
# Two-Wire Control Register Target

This block is the serial control port of a multi-output clock source. It listens on an open-drain two-wire bus, answers its own fixed device address and gives the controller read and write access to a bank of six 8-bit control registers. The controller moves one register at a time or a run of registers at once. In a run, the controller names a byte count when it writes, and the target reports a byte count before any data when it reads. The register bank leaves the block as a parallel bus. Decoded fields drive six per-output enables and an output-swing selection.

Both bus lines are sampled on the system clock through synchronizers. START and STOP conditions are found from the sampled lines. The target pulls the data line low only while the bus clock is low. It never holds the clock line. The register contents come back to their default values on reset.

The first byte after the address is the command. Its bit 7 picks the access kind: 1 means a single-register access, 0 means a counted block access. Its bits 6:0 give the first register index.

Top module: `clkctl_smb_target`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal 0x6B. Bit 0 is the direction: 0 is write and 1 is read. For any other address the target leaves SDA released for that byte and for every later byte up to the next START, and no register changes.
- R2: After reset the registers hold these values. Index 0 holds 0x00, index 1 holds 0x15, index 2 holds 0xE0, index 3 holds 0x08, index 4 holds 0x06 and index 5 holds 0xD8. regs_o carries index k in bits 8k+7:8k.
- R3: Single write: a command with bit 7 = 1 is followed by one data byte, which is stored into the register indexed by command bits 6:0. Each byte is acknowledged.
- R4: Single read: the controller sends the address with write direction and a command with bit 7 = 1, then a repeated START and the address with read direction. The target then returns the indexed register, most significant bit first.
- R5: Block write: a command with bit 7 = 0 is followed by a count byte N and then data bytes. The first N data bytes go to ascending registers, starting at the command index. Data bytes past N are acknowledged and dropped.
- R6: Block read: after the read address, the target first sends the current content of register 4. It then sends registers in ascending order from the command index, until the controller answers a byte with NACK.
- R7: A write to an index of 6 or more is acknowledged and has no effect. A read from such an index returns 0x00.
- R8: out_en_o bits 0, 1 and 2 follow register 1 bits 4, 2 and 0. out_en_o bits 3, 4 and 5 follow register 2 bits 7, 6 and 5. A 1 means the output is enabled.
- R9: amp_sel_o follows register 5 bit 7. amp_lvl_o follows register 5 bits 6:4, where code c means a swing of 300 + 100·c mV.
- R10: The target changes sda_oe only while SCL is low. No register changes while SCL is high.
- R11: A block write that ends with a STOP after any complete data byte keeps every byte already received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Pull data line low when 1 |
| regs_o | output | 48 | Register bank, index k in bits 8k+7:8k |
| out_en_o | output | 6 | Per-output enables |
| amp_sel_o | output | 1 | Custom output swing select |
| amp_lvl_o | output | 3 | Custom swing level code |

## Verification
The bound checker watches the pin-level rules on every cycle. The data line and the register bank only move while SCL is low, no register is written while the target drives an acknowledge or a data bit, and the enable and swing outputs always track their register fields. Whether a transfer is framed correctly can only be shown by the bench's transactions. This covers address matching, the count byte, ascending register order, dropped bytes past the count, reads beyond the bank and early STOP. In those transactions the bench compares each received byte and each acknowledge with a register model that it keeps for itself.

// File: rtl/smbt_pkg.sv
package smbt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RXACK,
        ST_TX,
        ST_TXACK
    } st_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_CMD,
        PH_CNT,
        PH_DATA
    } ph_e;
endpackage

// File: rtl/smbt_line_cond.sv
module smbt_line_cond #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_s
);
    logic [SYNC-1:0] scl_sy_q, sda_sy_q;
    logic            scl_p_q, sda_p_q;
    logic            scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sy_q <= '1;
            sda_sy_q <= '1;
            scl_p_q  <= 1'b1;
            sda_p_q  <= 1'b1;
        end else begin
            scl_sy_q <= {scl_sy_q[SYNC-2:0], scl_i};
            sda_sy_q <= {sda_sy_q[SYNC-2:0], sda_i};
            scl_p_q  <= scl_sy_q[SYNC-1];
            sda_p_q  <= sda_sy_q[SYNC-1];
        end
    end

    assign scl_s     = scl_sy_q[SYNC-1];
    assign sda_s     = sda_sy_q[SYNC-1];
    assign scl_rise  = scl_s & ~scl_p_q;
    assign scl_fall  = ~scl_s & scl_p_q;
    assign start_det = scl_s & scl_p_q & sda_p_q & ~sda_s;
    assign stop_det  = scl_s & scl_p_q & ~sda_p_q & sda_s;
endmodule

// File: rtl/smbt_xfer_engine.sv
module smbt_xfer_engine
    import smbt_pkg::*;
#(
    parameter int               NREG    = 6,
    parameter logic [6:0]       ADDR7   = 7'h6B,
    parameter int               CNT_IDX = 4,
    parameter logic [NREG*8-1:0] RST_VAL = 48'hD8_06_08_E0_15_00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_s,
    output logic              sda_oe,
    output logic [NREG*8-1:0] regs_o
);
    typedef struct packed {
        st_e                  st;
        ph_e                  ph;
        logic [3:0]           bits;
        logic [7:0]           sh;
        logic [7:0]           tx;
        logic [6:0]           ptr;
        logic                 blk;
        logic                 rd;
        logic                 once;
        logic [7:0]           left;
        logic                 oe;
        logic [NREG-1:0][7:0] regs;
    } state_t;

    state_t     s_d, s_q;
    logic [7:0] rd_byte;
    logic       wr_ok;
    logic [7:0] tx_nxt;

    always_comb begin
        rd_byte = 8'h00;
        for (int k = 0; k < NREG; k++) begin
            if (s_q.ptr == 7'(k)) rd_byte = s_q.regs[k];
        end
    end

    always_comb begin
        s_d    = s_q;
        wr_ok  = 1'b0;
        tx_nxt = {s_q.tx[6:0], 1'b0};
        if (start_det) begin
            s_d.st   = ST_RX;
            s_d.ph   = PH_ADDR;
            s_d.bits = '0;
            s_d.oe   = 1'b0;
            s_d.rd   = 1'b0;
        end else if (stop_det) begin
            s_d.st = ST_IDLE;
            s_d.oe = 1'b0;
        end else begin
            unique case (s_q.st)
                ST_RX: begin
                    if (scl_rise) begin
                        s_d.sh   = {s_q.sh[6:0], sda_s};
                        s_d.bits = s_q.bits + 4'd1;
                    end else if (scl_fall && s_q.bits == 4'd8) begin
                        s_d.bits = '0;
                        s_d.st   = ST_RXACK;
                        s_d.oe   = 1'b1;
                        unique case (s_q.ph)
                            PH_ADDR: begin
                                if (s_q.sh[7:1] != ADDR7) begin
                                    s_d.st = ST_IDLE;
                                    s_d.oe = 1'b0;
                                end else if (s_q.sh[0]) begin
                                    s_d.rd = 1'b1;
                                    if (s_q.blk) begin
                                        s_d.tx = s_q.regs[CNT_IDX];
                                    end else begin
                                        s_d.tx  = rd_byte;
                                        s_d.ptr = s_q.ptr + 7'd1;
                                    end
                                end else begin
                                    s_d.ph = PH_CMD;
                                end
                            end
                            PH_CMD: begin
                                s_d.ptr  = s_q.sh[6:0];
                                s_d.blk  = ~s_q.sh[7];
                                s_d.ph   = s_q.sh[7] ? PH_DATA : PH_CNT;
                                s_d.once = 1'b1;
                            end
                            PH_CNT: begin
                                s_d.left = s_q.sh;
                                s_d.ph   = PH_DATA;
                            end
                            default: begin
                                wr_ok = s_q.blk ? (s_q.left != 8'd0) : s_q.once;
                                for (int k = 0; k < NREG; k++) begin
                                    if (wr_ok && s_q.ptr == 7'(k)) s_d.regs[k] = s_q.sh;
                                end
                                if (wr_ok) s_d.ptr = s_q.ptr + 7'd1;
                                if (s_q.blk && s_q.left != 8'd0) s_d.left = s_q.left - 8'd1;
                                s_d.once = 1'b0;
                            end
                        endcase
                    end
                end
                ST_RXACK: begin
                    if (scl_fall) begin
                        if (s_q.rd) begin
                            s_d.st   = ST_TX;
                            s_d.bits = '0;
                            s_d.oe   = ~s_q.tx[7];
                        end else begin
                            s_d.st = ST_RX;
                            s_d.oe = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        s_d.bits = s_q.bits + 4'd1;
                    end else if (scl_fall) begin
                        if (s_q.bits == 4'd8) begin
                            s_d.st = ST_TXACK;
                            s_d.oe = 1'b0;
                        end else begin
                            s_d.tx = tx_nxt;
                            s_d.oe = ~tx_nxt[7];
                        end
                    end
                end
                ST_TXACK: begin
                    if (scl_rise) begin
                        if (sda_s) begin
                            s_d.st = ST_IDLE;
                        end else begin
                            s_d.tx  = rd_byte;
                            s_d.ptr = s_q.ptr + 7'd1;
                        end
                    end else if (scl_fall) begin
                        s_d.st   = ST_TX;
                        s_d.bits = '0;
                        s_d.oe   = ~s_q.tx[7];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= ST_IDLE;
            s_q.ph   <= PH_ADDR;
            s_q.regs <= RST_VAL;
        end else begin
            s_q <= s_d;
        end
    end

    assign sda_oe = s_q.oe;
    assign regs_o = s_q.regs;
endmodule

// File: rtl/smbt_field_map.sv
module smbt_field_map #(
    parameter int               NREG    = 6,
    parameter int               NOUT    = 6,
    parameter logic [NOUT*8-1:0] OE_BITS = {8'd21, 8'd22, 8'd23, 8'd8, 8'd10, 8'd12},
    parameter int               AMP_IDX = 5
) (
    input  logic [NREG*8-1:0] regs_i,
    output logic [NOUT-1:0]   out_en_o,
    output logic              amp_sel_o,
    output logic [2:0]        amp_lvl_o
);
    localparam int AMP_BASE = AMP_IDX * 8;

    for (genvar g = 0; g < NOUT; g++) begin : g_oe
        assign out_en_o[g] = regs_i[OE_BITS[g*8 +: 8]];
    end

    assign amp_sel_o = regs_i[AMP_BASE + 7];
    assign amp_lvl_o = regs_i[AMP_BASE + 4 +: 3];
endmodule

// File: rtl/clkctl_smb_target.sv
module clkctl_smb_target #(
    parameter int               NREG    = 6,
    parameter int               NOUT    = 6,
    parameter logic [6:0]       ADDR7   = 7'h6B,
    parameter int               CNT_IDX = 4,
    parameter int               AMP_IDX = 5,
    parameter logic [NREG*8-1:0] RST_VAL = 48'hD8_06_08_E0_15_00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [NREG*8-1:0] regs_o,
    output logic [NOUT-1:0]   out_en_o,
    output logic              amp_sel_o,
    output logic [2:0]        amp_lvl_o
);
    logic scl_rise, scl_fall, start_det, stop_det, sda_s;

    smbt_line_cond #(.SYNC(2)) line_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s)
    );

    smbt_xfer_engine #(
        .NREG(NREG), .ADDR7(ADDR7), .CNT_IDX(CNT_IDX), .RST_VAL(RST_VAL)
    ) eng_i (
        .clk(clk), .rst_n(rst_n),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
        .sda_oe(sda_oe), .regs_o(regs_o)
    );

    smbt_field_map #(.NREG(NREG), .NOUT(NOUT), .AMP_IDX(AMP_IDX)) map_i (
        .regs_i(regs_o), .out_en_o(out_en_o),
        .amp_sel_o(amp_sel_o), .amp_lvl_o(amp_lvl_o)
    );
endmodule

// File: rtl/clkctl_smb_chk.sv
module clkctl_smb_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_i,
    input logic        sda_oe,
    input logic [47:0] regs_o,
    input logic [5:0]  out_en_o,
    input logic        amp_sel_o,
    input logic [2:0]  amp_lvl_o
);
    // R10
    sda_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    // R10
    regs_quiet_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_o) |-> !scl_i);

    // R3
    no_write_while_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe && $past(sda_oe)) |-> $stable(regs_o));

    // R8
    oe_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_o == {regs_o[21], regs_o[22], regs_o[23], regs_o[8], regs_o[10], regs_o[12]});

    // R9
    amp_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        {amp_sel_o, amp_lvl_o} == regs_o[47:44]);
endmodule

bind clkctl_smb_target clkctl_smb_chk chk_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
    .regs_o(regs_o), .out_en_o(out_en_o),
    .amp_sel_o(amp_sel_o), .amp_lvl_o(amp_lvl_o)
);

// File: tb/clkctl_smb_target_tb.sv
module clkctl_smb_target_tb_top;
    localparam int Q = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic        sda_oe;
    logic [47:0] regs_o;
    logic [5:0]  out_en_o;
    logic        amp_sel_o;
    logic [2:0]  amp_lvl_o;
    wire         sda_line = sda_m & ~sda_oe;

    int nvec = 0;
    int nfail = 0;
    logic [7:0] mdl [6];

    always #5 clk = ~clk;

    clkctl_smb_target dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .regs_o(regs_o), .out_en_o(out_en_o),
        .amp_sel_o(amp_sel_o), .amp_lvl_o(amp_lvl_o)
    );

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q);
            scl_m = 1'b1; wq(2*Q);
            scl_m = 1'b0; wq(Q);
        end
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        ack = (sda_line == 1'b0);
        wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q);
            scl_m = 1'b1; wq(Q);
            b[i] = sda_line;
            wq(Q);
            scl_m = 1'b0;
        end
        wq(Q);
        sda_m = ~give_ack; wq(Q);
        scl_m = 1'b1; wq(2*Q);
        scl_m = 1'b0; wq(Q);
        sda_m = 1'b1;
    endtask

    function automatic logic [47:0] mdl_flat();
        return {mdl[5], mdl[4], mdl[3], mdl[2], mdl[1], mdl[0]};
    endfunction

    task automatic chk_outputs(input string req);
        chk(req, regs_o, mdl_flat());
        chk({req, "_R8"}, 48'(out_en_o),
            48'({mdl[2][5], mdl[2][6], mdl[2][7], mdl[1][0], mdl[1][2], mdl[1][4]}));
        chk({req, "_R9"}, 48'({amp_sel_o, amp_lvl_o}), 48'(mdl[5][7:4]));
    endtask

    task automatic single_write(input logic [6:0] idx, input logic [7:0] v, output logic allack);
        logic a0, a1, a2;
        bus_start();
        put_byte(8'hD6, a0);
        put_byte({1'b1, idx}, a1);
        put_byte(v, a2);
        bus_stop();
        allack = a0 & a1 & a2;
        if (idx < 7'd6) mdl[idx[2:0]] = v;
    endtask

    task automatic single_read(input logic [6:0] idx, output logic [7:0] v);
        logic a;
        bus_start();
        put_byte(8'hD6, a);
        put_byte({1'b1, idx}, a);
        bus_start();
        put_byte(8'hD7, a);
        get_byte(1'b0, v);
        bus_stop();
    endtask

    initial begin
        logic       ack;
        logic [7:0] rb;
        mdl[0] = 8'h00; mdl[1] = 8'h15; mdl[2] = 8'hE0;
        mdl[3] = 8'h08; mdl[4] = 8'h06; mdl[5] = 8'hD8;
        wq(4);
        rst_n = 1'b1;
        wq(4);

        // R2 reset contents and decoded fields
        chk_outputs("R2");

        // R4 single read of every register, MSB first
        for (int r = 0; r < 6; r++) begin
            single_read(7'(r), rb);
            chk("R4", 48'(rb), 48'(mdl[r]));
        end

        // R3 single write sweep with read back
        for (int r = 0; r < 6; r++) begin
            for (int p = 0; p < 5; p++) begin
                logic [7:0] v;
                v = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : (p == 2) ? 8'hA5 :
                    (p == 3) ? 8'h5A : 8'(r * 37 + 1);
                single_write(7'(r), v, ack);
                chk("R3_ack", 48'(ack), 48'd1);
                chk_outputs("R3");
                single_read(7'(r), rb);
                chk("R4", 48'(rb), 48'(v));
            end
        end

        // R7 writes above the bank are acknowledged and dropped, reads give zero
        for (int x = 6; x < 10; x++) begin
            single_write(7'(x), 8'h3C, ack);
            chk("R7_ack", 48'(ack), 48'd1);
            chk_outputs("R7");
            single_read(7'(x), rb);
            chk("R7", 48'(rb), 48'h0);
        end

        // R5 block write with counts 0..6, one byte more than the bank sent
        for (int n = 0; n <= 6; n++) begin
            logic a;
            bus_start();
            put_byte(8'hD6, a); chk("R5_ack", 48'(a), 48'd1);
            put_byte(8'h00, a); chk("R5_ack", 48'(a), 48'd1);
            put_byte(8'(n), a); chk("R5_ack", 48'(a), 48'd1);
            for (int i = 0; i < 7; i++) begin
                logic [7:0] v;
                v = 8'(n * 16 + i + 1);
                put_byte(v, a);
                chk("R5_ack", 48'(a), 48'd1);
                if (i < n) mdl[i] = v;
            end
            bus_stop();
            chk_outputs("R5");
        end

        // R11 block write cut short by STOP after two data bytes
        begin
            logic a;
            bus_start();
            put_byte(8'hD6, a);
            put_byte(8'h02, a);
            put_byte(8'd4, a);
            put_byte(8'h9E, a); mdl[2] = 8'h9E;
            put_byte(8'h4B, a); mdl[3] = 8'h4B;
            bus_stop();
            chk_outputs("R11");
        end

        // R6 block read: count byte then ascending registers, varied lengths and counts
        for (int k = 1; k <= 7; k++) begin
            logic a;
            single_write(7'd4, 8'(k + 2), ack);
            bus_start();
            put_byte(8'hD6, a);
            put_byte(8'h00, a);
            bus_start();
            put_byte(8'hD7, a);
            chk("R6_ack", 48'(a), 48'd1);
            get_byte(1'b1, rb);
            chk("R6_count", 48'(rb), 48'(mdl[4]));
            for (int i = 0; i < k; i++) begin
                get_byte(i != k - 1, rb);
                chk("R6", 48'(rb), (i < 6) ? 48'(mdl[i]) : 48'h0);
            end
            bus_stop();
        end

        // R7 block read that runs past the top of the bank
        begin
            logic a;
            bus_start();
            put_byte(8'hD6, a);
            put_byte(8'h04, a);
            bus_start();
            put_byte(8'hD7, a);
            get_byte(1'b1, rb);
            chk("R6_count", 48'(rb), 48'(mdl[4]));
            for (int i = 4; i < 8; i++) begin
                get_byte(i != 7, rb);
                chk("R7_blk", 48'(rb), (i < 6) ? 48'(mdl[i]) : 48'h0);
            end
            bus_stop();
        end

        // R1 foreign addresses: no acknowledge, later bytes ignored, no register change
        for (int ad = 0; ad < 128; ad += 3) begin
            if (ad != 7'h6B) begin
                logic a;
                bus_start();
                put_byte({7'(ad), 1'b0}, a); chk("R1_nack", 48'(a), 48'd0);
                put_byte(8'h81, a);          chk("R1_ignored", 48'(a), 48'd0);
                put_byte(8'h00, a);          chk("R1_ignored", 48'(a), 48'd0);
                bus_stop();
                chk_outputs("R1");
            end
        end
        foreach (mdl[i]) begin end
        begin
            logic a;
            bus_start();
            put_byte({7'h6A, 1'b1}, a); chk("R1_nack", 48'(a), 48'd0);
            get_byte(1'b0, rb);         chk("R1_released", 48'(rb), 48'hFF);
            bus_stop();
            bus_start();
            put_byte({7'h6C, 1'b0}, a); chk("R1_nack", 48'(a), 48'd0);
            bus_stop();
            bus_start();
            put_byte(8'hD6, a);         chk("R1_ack", 48'(a), 48'd1);
            bus_stop();
            chk_outputs("R1");
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule